// File: doc/BRIEF.md
# NAND Physical Page Layout Router

The router sits between a byte-serial flash port and two logical buffers: a data buffer holding the page payload, and a spare buffer holding the bad-block marker, the metadata and the error-correction bytes. A raw flash page is not stored in logical order. It opens with four metadata bytes. Full packets then alternate with their ECC bytes. A six-byte bad-block marker is placed exactly at the physical offset equal to the page size, so it cuts the last packet in two, and that packet's ECC comes last. The router walks this layout one byte at a time and gives each byte its logical destination.

In read mode the router consumes bytes from the flash side under a valid/ready handshake. It writes each byte into the data or spare buffer at the correct address. In write mode it presents buffer addresses and streams the fetched bytes to the flash side in physical order. The buffers are read combinationally. Two skip controls, one for the data region and one for the spare region, let bytes be consumed without being stored, or emitted as 0xFF without being fetched. This supports spare-only or data-only transfers. Mode and skip controls are latched when a page starts. A done flag rises after the final ECC byte.

Top module: `nand_page_router`

## Requirements
- R1: A `start` pulse while idle latches the mode and skip controls and raises `busy` on the next cycle. A `start` while busy is ignored, and the transfer continues at its current byte.
- R2: The first 4 physical bytes are metadata and map to spare addresses 6, 7, 8, 9 in order.
- R3: Full packets (data then ECC) repeat while the bytes left before the marker offset, counted from the end of the metadata, exceed one packet. Data bytes map to consecutive data addresses starting at 0 across the whole page.
- R4: Each packet has ceil(strength × 15 / 8) ECC bytes. The ECC of packet i maps to spare addresses starting at 10 + i × ecc_bytes, in the same order for the split last packet.
- R5: The marker starts at physical offset equal to the page size and maps to spare addresses 0 to 5. The last packet's remaining bytes are split around it, and data addresses continue without a gap across the marker.
- R6: A byte advances only when `rd_valid` and `rd_ready` are both high (read) or when `wr_valid` and `wr_ready` are both high (write). No buffer write occurs without an accepted byte.
- R7: In read mode each accepted byte raises exactly one of `data_we` and `spare_we`, with the write data equal to `rd_data`.
- R8: In write mode `wr_data` equals `data_rdata` or `spare_rdata`, taken at the address the router presents for the current byte. No buffer write enable rises.
- R9: With data skip set, data-region bytes are consumed without `data_we` in read mode and are sent as 0xFF in write mode. Spare bytes are unaffected.
- R10: With spare skip set, spare-region bytes are consumed without `spare_we` in read mode and are sent as 0xFF in write mode. Data bytes are unaffected.
- R11: One cycle after the final ECC byte is accepted, `busy` is low and `done` is high. `done` stays high until the next start.
- R12: After reset `busy`, `done`, `rd_ready`, `wr_valid`, `data_we` and `spare_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin routing one page |
| write_mode | input | 1 | 1: buffers to flash, 0: flash to buffers |
| skip_data | input | 1 | Do not store or fetch data-region bytes |
| skip_spare | input | 1 | Do not store or fetch spare-region bytes |
| busy | output | 1 | Page transfer in progress |
| done | output | 1 | Last page finished |
| rd_valid | input | 1 | Flash byte available (read mode) |
| rd_data | input | 8 | Flash byte (read mode) |
| rd_ready | output | 1 | Router takes a flash byte |
| wr_valid | output | 1 | Router offers a byte to flash (write mode) |
| wr_data | output | 8 | Byte offered to flash |
| wr_ready | input | 1 | Flash takes the byte |
| data_addr | output | DAW | Data buffer address |
| data_we | output | 1 | Data buffer write enable |
| data_wdata | output | 8 | Data buffer write byte |
| data_rdata | input | 8 | Data buffer read byte at `data_addr` |
| spare_addr | output | SAW | Spare buffer address |
| spare_we | output | 1 | Spare buffer write enable |
| spare_wdata | output | 8 | Spare buffer write byte |
| spare_rdata | input | 8 | Spare buffer read byte at `spare_addr` |

## Verification
Routing is combinational from the registered position, so the destination of a byte is due in the same cycle its handshake is offered. The bench drives each byte just after a rising edge and compares addresses, enables and data at the following falling edge, before the edge that accepts it. `busy` is due one edge after `start`, and `done` one edge after the final acceptance. Those checks are made at the falling edge after the corresponding rising edge. The expected physical-to-logical map of a whole small page is computed in the bench from the layout rule. It is swept byte by byte in both directions, with gapped handshakes and with every skip setting.

// File: rtl/nand_layout_pkg.sv
package nand_layout_pkg;

    localparam int META_BYTES      = 4;
    localparam int MARK_BYTES      = 6;
    localparam int MARK_SPARE_BASE = 0;
    localparam int META_SPARE_BASE = MARK_BYTES;
    localparam int ECC_SPARE_BASE  = MARK_BYTES + META_BYTES;
    localparam int GF_ORDER        = 15;

    // Physical regions in the order they appear on the flash
    typedef enum logic [2:0] {
        RG_META = 3'd0,
        RG_PKT  = 3'd1,
        RG_ECC  = 3'd2,
        RG_HEAD = 3'd3,
        RG_MARK = 3'd4,
        RG_TAIL = 3'd5,
        RG_LECC = 3'd6
    } region_e;

    typedef struct packed {
        logic write_mode;
        logic skip_data;
        logic skip_spare;
    } xfer_cfg_t;

    function automatic int ecc_bytes_for(input int strength);
        return (strength * GF_ORDER + 7) / 8;
    endfunction

    // Count of whole packets before the one split by the marker
    function automatic int full_packets(input int page, input int pkt, input int ecc);
        int left;
        int k;
        left = page - META_BYTES;
        k = 0;
        while (left > pkt) begin
            left = left - (pkt + ecc);
            k++;
        end
        return k;
    endfunction

    function automatic logic is_data_region(input region_e r);
        return (r == RG_PKT) || (r == RG_HEAD) || (r == RG_TAIL);
    endfunction

endpackage

// File: rtl/nand_layout_seq.sv
module nand_layout_seq
    import nand_layout_pkg::*;
#(
    parameter int PKT_BYTES  = 512,
    parameter int ECC_BYTES  = 15,
    parameter int FULL_PKTS  = 3,
    parameter int HEAD_BYTES = 463,
    parameter int DAW        = 11,
    parameter int SAW        = 7,
    parameter int CW         = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  xfer_cfg_t      cfg_in,
    input  logic           accept,
    output logic           busy,
    output logic           done,
    output region_e        region,
    output logic [CW-1:0]  cnt,
    output logic [DAW-1:0] data_ptr,
    output logic [SAW-1:0] ecc_ptr,
    output xfer_cfg_t      cfg
);

    localparam int TAIL_BYTES = PKT_BYTES - HEAD_BYTES;
    localparam int PCW        = $clog2(FULL_PKTS + 2);
    localparam region_e AFTER_PKTS = (HEAD_BYTES > 0) ? RG_HEAD : RG_MARK;
    localparam region_e AFTER_MARK = (TAIL_BYTES > 0) ? RG_TAIL : RG_LECC;
    localparam region_e AFTER_META = (FULL_PKTS > 0) ? RG_PKT : AFTER_PKTS;

    logic [PCW-1:0] pkt_cnt;
    logic [CW-1:0]  len;
    logic           last;

    always_comb begin
        case (region)
            RG_META:         len = CW'(META_BYTES);
            RG_PKT:          len = CW'(PKT_BYTES);
            RG_ECC, RG_LECC: len = CW'(ECC_BYTES);
            RG_HEAD:         len = CW'(HEAD_BYTES);
            RG_MARK:         len = CW'(MARK_BYTES);
            RG_TAIL:         len = CW'(TAIL_BYTES);
            default:         len = CW'(1);
        endcase
        last = (cnt == len - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            region   <= RG_META;
            cnt      <= '0;
            data_ptr <= '0;
            ecc_ptr  <= SAW'(ECC_SPARE_BASE);
            pkt_cnt  <= '0;
            cfg      <= '0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                done     <= 1'b0;
                region   <= RG_META;
                cnt      <= '0;
                data_ptr <= '0;
                ecc_ptr  <= SAW'(ECC_SPARE_BASE);
                pkt_cnt  <= '0;
                cfg      <= cfg_in;
            end
        end else if (accept) begin
            if (is_data_region(region))
                data_ptr <= data_ptr + 1'b1;
            if (region == RG_ECC || region == RG_LECC)
                ecc_ptr <= ecc_ptr + 1'b1;
            if (!last) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                case (region)
                    RG_META: region <= AFTER_META;
                    RG_PKT:  region <= RG_ECC;
                    RG_ECC: begin
                        pkt_cnt <= pkt_cnt + 1'b1;
                        region  <= (pkt_cnt == PCW'(FULL_PKTS - 1)) ? AFTER_PKTS : RG_PKT;
                    end
                    RG_HEAD: region <= RG_MARK;
                    RG_MARK: region <= AFTER_MARK;
                    RG_TAIL: region <= RG_LECC;
                    default: begin
                        region <= RG_META;
                        busy   <= 1'b0;
                        done   <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/nand_layout_route.sv
module nand_layout_route
    import nand_layout_pkg::*;
#(
    parameter int DAW = 11,
    parameter int SAW = 7,
    parameter int CW  = 10
) (
    input  logic           busy,
    input  region_e        region,
    input  logic [CW-1:0]  cnt,
    input  logic [DAW-1:0] data_ptr,
    input  logic [SAW-1:0] ecc_ptr,
    input  xfer_cfg_t      cfg,
    input  logic           rd_valid,
    input  logic [7:0]     rd_data,
    output logic           rd_ready,
    output logic           wr_valid,
    output logic [7:0]     wr_data,
    input  logic           wr_ready,
    output logic [DAW-1:0] data_addr,
    output logic           data_we,
    output logic [7:0]     data_wdata,
    input  logic [7:0]     data_rdata,
    output logic [SAW-1:0] spare_addr,
    output logic           spare_we,
    output logic [7:0]     spare_wdata,
    input  logic [7:0]     spare_rdata,
    output logic           accept
);

    logic to_data;
    logic rd_take;

    always_comb begin
        to_data  = is_data_region(region);
        rd_ready = busy & ~cfg.write_mode;
        wr_valid = busy & cfg.write_mode;
        rd_take  = rd_ready & rd_valid;
        accept   = rd_take | (wr_valid & wr_ready);

        data_addr = data_ptr;
        case (region)
            RG_MARK: spare_addr = SAW'(MARK_SPARE_BASE) + SAW'(cnt);
            RG_META: spare_addr = SAW'(META_SPARE_BASE) + SAW'(cnt);
            default: spare_addr = ecc_ptr;
        endcase

        data_we     = rd_take & to_data & ~cfg.skip_data;
        spare_we    = rd_take & ~to_data & ~cfg.skip_spare;
        data_wdata  = rd_data;
        spare_wdata = rd_data;

        if (to_data)
            wr_data = cfg.skip_data ? 8'hFF : data_rdata;
        else
            wr_data = cfg.skip_spare ? 8'hFF : spare_rdata;
    end

endmodule

// File: rtl/nand_page_router.sv
module nand_page_router
    import nand_layout_pkg::*;
#(
    parameter int PAGE_BYTES   = 2048,
    parameter int PKT_BYTES    = 512,
    parameter int ECC_STRENGTH = 8,
    localparam int ECC_BYTES   = ecc_bytes_for(ECC_STRENGTH),
    localparam int FULL_PKTS   = full_packets(PAGE_BYTES, PKT_BYTES, ECC_BYTES),
    localparam int HEAD_BYTES  = PAGE_BYTES - META_BYTES - FULL_PKTS * (PKT_BYTES + ECC_BYTES),
    localparam int STEPS       = FULL_PKTS + 1,
    localparam int SPARE_BYTES = ECC_SPARE_BASE + STEPS * ECC_BYTES,
    localparam int DAW         = $clog2(PAGE_BYTES),
    localparam int SAW         = $clog2(SPARE_BYTES),
    localparam int CW          = $clog2(PKT_BYTES + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           write_mode,
    input  logic           skip_data,
    input  logic           skip_spare,
    output logic           busy,
    output logic           done,
    input  logic           rd_valid,
    input  logic [7:0]     rd_data,
    output logic           rd_ready,
    output logic           wr_valid,
    output logic [7:0]     wr_data,
    input  logic           wr_ready,
    output logic [DAW-1:0] data_addr,
    output logic           data_we,
    output logic [7:0]     data_wdata,
    input  logic [7:0]     data_rdata,
    output logic [SAW-1:0] spare_addr,
    output logic           spare_we,
    output logic [7:0]     spare_wdata,
    input  logic [7:0]     spare_rdata
);

    region_e        region;
    logic [CW-1:0]  cnt;
    logic [DAW-1:0] data_ptr;
    logic [SAW-1:0] ecc_ptr;
    xfer_cfg_t      cfg;
    xfer_cfg_t      cfg_in;
    logic           accept;

    assign cfg_in = '{write_mode: write_mode, skip_data: skip_data, skip_spare: skip_spare};

    nand_layout_seq #(
        .PKT_BYTES (PKT_BYTES),
        .ECC_BYTES (ECC_BYTES),
        .FULL_PKTS (FULL_PKTS),
        .HEAD_BYTES(HEAD_BYTES),
        .DAW       (DAW),
        .SAW       (SAW),
        .CW        (CW)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_in  (cfg_in),
        .accept  (accept),
        .busy    (busy),
        .done    (done),
        .region  (region),
        .cnt     (cnt),
        .data_ptr(data_ptr),
        .ecc_ptr (ecc_ptr),
        .cfg     (cfg)
    );

    nand_layout_route #(
        .DAW(DAW),
        .SAW(SAW),
        .CW (CW)
    ) u_route (
        .busy       (busy),
        .region     (region),
        .cnt        (cnt),
        .data_ptr   (data_ptr),
        .ecc_ptr    (ecc_ptr),
        .cfg        (cfg),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_ready   (rd_ready),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .data_addr  (data_addr),
        .data_we    (data_we),
        .data_wdata (data_wdata),
        .data_rdata (data_rdata),
        .spare_addr (spare_addr),
        .spare_we   (spare_we),
        .spare_wdata(spare_wdata),
        .spare_rdata(spare_rdata),
        .accept     (accept)
    );

endmodule

// File: rtl/nand_page_router_chk.sv
module nand_page_router_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic rd_valid,
    input logic rd_ready,
    input logic wr_valid,
    input logic data_we,
    input logic spare_we
);

    a_r1_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r6_write_needs_handshake: assert property (@(posedge clk) disable iff (rst)
        (data_we || spare_we) |-> (rd_valid && rd_ready));

    a_r7_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({data_we, spare_we}));

    a_r8_no_store_in_write: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (!data_we && !spare_we));

    a_r11_done_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind nand_page_router nand_page_router_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_valid(rd_valid),
    .rd_ready(rd_ready),
    .wr_valid(wr_valid),
    .data_we (data_we),
    .spare_we(spare_we)
);

// File: tb/tb_nand_page_router.sv
`timescale 1ns/1ps
module tb_nand_page_router;

    localparam int PAGE = 64;
    localparam int PKT  = 16;
    localparam int STR  = 1;
    localparam int ECCB = (STR * 15 + 7) / 8;
    localparam int DAW  = 6;
    localparam int SAW  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, write_mode = 1'b0, skip_data = 1'b0, skip_spare = 1'b0;
    logic busy, done, rd_valid = 1'b0, rd_ready, wr_valid, wr_ready = 1'b0;
    logic [7:0] rd_data = 8'h00, wr_data, data_wdata, spare_wdata, data_rdata, spare_rdata;
    logic [DAW-1:0] data_addr;
    logic [SAW-1:0] spare_addr;
    logic data_we, spare_we;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int    nbytes;
    bit    exp_data [128];
    int    exp_addr [128];
    string exp_req  [128];

    always #10 clk = ~clk;

    // Buffer models: read byte is a fixed function of address
    assign data_rdata  = {2'b00, data_addr} ^ 8'h33;
    assign spare_rdata = {3'b100, spare_addr};

    nand_page_router #(.PAGE_BYTES(PAGE), .PKT_BYTES(PKT), .ECC_STRENGTH(STR)) dut (
        .clk(clk), .rst(rst), .start(start), .write_mode(write_mode),
        .skip_data(skip_data), .skip_spare(skip_spare), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .data_addr(data_addr), .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .spare_addr(spare_addr), .spare_we(spare_we), .spare_wdata(spare_wdata), .spare_rdata(spare_rdata)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int b);
        return 8'((b * 7 + 3) & 255);
    endfunction

    task automatic push(input bit d, input int a, input string r);
        exp_data[nbytes] = d;
        exp_addr[nbytes] = a;
        exp_req[nbytes]  = r;
        nbytes++;
    endtask

    // Build expected physical-to-logical map from the layout rule
    task automatic build_map();
        int left, dptr, eptr, head;
        nbytes = 0; dptr = 0; eptr = 10;
        for (int i = 0; i < 4; i++) push(1'b0, 6 + i, "R2");
        left = PAGE - 4;
        while (left > PKT) begin
            for (int i = 0; i < PKT; i++) begin push(1'b1, dptr, "R3"); dptr++; end
            for (int i = 0; i < ECCB; i++) begin push(1'b0, eptr, "R4"); eptr++; end
            left = left - PKT - ECCB;
        end
        head = left;
        for (int i = 0; i < head; i++) begin push(1'b1, dptr, "R5"); dptr++; end
        for (int i = 0; i < 6; i++) push(1'b0, i, "R5");
        for (int i = 0; i < PKT - head; i++) begin push(1'b1, dptr, "R5"); dptr++; end
        for (int i = 0; i < ECCB; i++) begin push(1'b0, eptr, "R4"); eptr++; end
    endtask

    task automatic run_page(input bit wm, input bit sd, input bit ss, input bit gaps, input bit poke_start);
        int b, cyc;
        bit hs;
        string tag;
        @(posedge clk); #1;
        start = 1'b1; write_mode = wm; skip_data = sd; skip_spare = ss;
        @(posedge clk); #1;
        start = 1'b0; write_mode = 1'b0; skip_data = 1'b0; skip_spare = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R1", "busy after start", busy, 1);
        b = 0; cyc = 0;
        while (b < nbytes) begin
            hs = !gaps || (cyc % 3 != 1);
            start = (poke_start && b == 10) ? 1'b1 : 1'b0;
            if (poke_start && b == 10) begin
                // R1: start while busy, with flipped mode bits, must be ignored
                write_mode = ~wm; skip_data = 1'b1; skip_spare = 1'b1;
            end else begin
                write_mode = 1'b0; skip_data = 1'b0; skip_spare = 1'b0;
            end
            if (wm) wr_ready = hs;
            else begin rd_valid = hs; rd_data = pat(b); end
            @(negedge clk);
            tag = (sd && exp_data[b]) ? "R9" : ((ss && !exp_data[b]) ? "R10" : exp_req[b]);
            if (!hs) begin
                if (!wm) check(!data_we && !spare_we, "R6", "store without valid", {data_we, spare_we}, 0);
            end else if (!wm) begin
                if (exp_data[b])
                    check(data_we == !sd && !spare_we && (sd || (int'(data_addr) == exp_addr[b] && data_wdata == pat(b))),
                          tag, "read data byte addr", int'(data_addr), exp_addr[b]);
                else
                    check(spare_we == !ss && !data_we && (ss || (int'(spare_addr) == exp_addr[b] && spare_wdata == pat(b))),
                          tag, "read spare byte addr", int'(spare_addr), exp_addr[b]);
            end else begin
                logic [7:0] e;
                if (exp_data[b]) e = sd ? 8'hFF : (8'(exp_addr[b]) ^ 8'h33);
                else             e = ss ? 8'hFF : (8'h80 | 8'(exp_addr[b]));
                check(wr_valid && !data_we && !spare_we && wr_data == e,
                      (tag == exp_req[b]) ? "R8" : tag, "write byte", int'(wr_data), int'(e));
            end
            @(posedge clk); #1;
            if (poke_start && b == 10)
                check(busy == 1'b1, "R1", "busy kept after start while busy", busy, 1);
            if (hs) b++;
            cyc++;
        end
        start = 1'b0; rd_valid = 1'b0; wr_ready = 1'b0;
        write_mode = 1'b0; skip_data = 1'b0; skip_spare = 1'b0;
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R11", "done after last byte", {busy, done}, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b1 && !rd_ready && !wr_valid, "R11", "done held", done, 1);
    endtask

    initial begin
        build_map();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !rd_ready && !wr_valid && !data_we && !spare_we,
              "R12", "reset state", {busy, done, rd_ready, wr_valid, data_we, spare_we}, 0);
        check(nbytes == 4 + PAGE + 6 + 4 * ECCB, "R4", "page length", nbytes, 4 + PAGE + 6 + 4 * ECCB);

        run_page(1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // plain read
        run_page(1'b0, 1'b0, 1'b0, 1'b1, 1'b1); // gapped read, start while busy
        run_page(1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // gapped write
        run_page(1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // write, start while busy
        run_page(1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // read, data skipped
        run_page(1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // read, spare skipped
        run_page(1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // write, data skipped
        run_page(1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // write, spare skipped

        summary();
    end

endmodule